// File: doc/BRIEF.md
# Minimal-Stage Column Compression Multiplier

This block is a purely combinational 8x8 unsigned multiplier. The two operands are ANDed bit by bit into a 64-bit partial-product matrix, and each bit is placed in the column that matches its weight. The matrix then passes through a fixed chain of compression stages built from full adders (three bits in, sum and carry out) and half adders (two bits in, sum and carry out). A counter's sum stays in its own column. Its carry moves one column up and enters the next stage.

Each stage removes only as many bits as it must to bring every column down to that stage's limit. The limits form the sequence 2, 3, 4, 6, 9, 13, ..., where each entry is the floor of 1.5 times the previous one. For 8-bit operands the stages use the limits 6, 4, 3 and 2, in that order. The two rows that are left are added by a ripple carry-propagate adder. Its carry out becomes the top product bit.

The multiplier is used wherever a fixed 8-bit unsigned product is needed inside a single combinational path. It has no clock and holds no state.

Top module: `daddaMul`

## Requirements
- R1: For every one of the 65536 operand pairs, `product` equals the unsigned product `opA * opB`, 16 bits wide.
- R2: The block is combinational: `product` follows a change of either operand without any clock edge.
- R3: When either operand is zero, `product` is zero, and this includes the power-up state with both operands held at zero.
- R4: When one operand equals 1, `product` equals the other operand zero-extended to 16 bits.
- R5: When one operand is a power of two 2^k (k from 0 to 7), `product` equals the other operand shifted left by k places.
- R6: Bit 15 of `product` can be set only when bit 7 of both operands is set. The largest product, 255 x 255, is 0xFE01.
- R7: Every compression stage keeps the weighted sum of its matrix unchanged, where a bit in column c carries weight 2^c. The stage limits are taken from the floor(1.5x) sequence that starts at 2, and the first limit is the largest entry below 8.
- R8: After the last stage, every column holds at most two bits and column 15 is empty. The ripple adder over columns 0 to 14 yields product bits 0 to 14, and its carry out is product bit 15.
- R9: Swapping the two operands does not change `product`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product of opA and opB |

## Verification
Every result is due in the same cycle as its stimulus, with zero clock latency. The driver changes the operands just after a rising edge and queues the value it expects. The monitor pops that value at the following falling edge, when the combinational path has long settled, so each check sees exactly the operands it was queued with. The check for R2 is different: it changes an operand between edges and samples a moment later, with no clock edge in between.

// File: rtl/daddaPkg.sv
package daddaPkg;
  localparam int OPW  = 8;
  localparam int COLS = 2 * OPW;
  localparam int MAXH = OPW;

  typedef logic [MAXH-1:0] colBits_t;
  typedef colBits_t [COLS-1:0] matrix_t;

  // number of compression stages: entries of the floor(1.5x) sequence below OPW
  function automatic int stageCount();
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < OPW) begin
      n++;
      d = (d * 3) / 2;
    end
    return n;
  endfunction

  // limit of stage s (s = 0 is the first stage, which has the largest limit)
  function automatic int stageLimit(int s);
    int seq [32];
    int n;
    int d;
    n = 0;
    d = 2;
    while (d < OPW) begin
      seq[n] = d;
      n++;
      d = (d * 3) / 2;
    end
    return seq[n-1-s];
  endfunction

  function automatic int initHeight(int c);
    if (c < OPW) return c + 1;
    else if (c < 2 * OPW - 1) return 2 * OPW - 1 - c;
    else return 0;
  endfunction

  // kind 0: height of column c entering stage s
  // kind 1: full adders in column c of stage s, kind 2: half adders
  function automatic int plan(int s, int c, int kind);
    int h  [COLS];
    int nh [COLS];
    int fa [COLS];
    int ha [COLS];
    int cin;
    int tot;
    int lim;
    int e;
    for (int k = 0; k < COLS; k++) h[k] = initHeight(k);
    for (int st = 0; st <= s; st++) begin
      if (kind == 0 && st == s) return h[c];
      lim = stageLimit(st);
      cin = 0;
      for (int k = 0; k < COLS; k++) begin
        tot = h[k] + cin;
        if (tot > lim) begin
          e = tot - lim;
          fa[k] = e / 2;
          ha[k] = e % 2;
        end else begin
          fa[k] = 0;
          ha[k] = 0;
        end
        nh[k] = h[k] - 2 * fa[k] - ha[k] + cin;
        cin = fa[k] + ha[k];
      end
      if (st == s) return (kind == 1) ? fa[c] : ha[c];
      for (int k = 0; k < COLS; k++) h[k] = nh[k];
    end
    return 0;
  endfunction
endpackage

// File: rtl/ppMatrix.sv
module ppMatrix
  import daddaPkg::*;
(
  input  logic [OPW-1:0] mulA,
  input  logic [OPW-1:0] mulB,
  output matrix_t        ppCols
);
  // bit i of mulB times bit j of mulA lands in column i+j
  for (genvar i = 0; i < OPW; i++) begin : g_row
    for (genvar j = 0; j < OPW; j++) begin : g_bit
      localparam int ROW = (i + j < OPW) ? i : OPW - 1 - j;
      assign ppCols[i+j][ROW] = mulA[j] & mulB[i];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_fill
    for (genvar p = initHeight(c); p < MAXH; p++) begin : g_zero
      assign ppCols[c][p] = 1'b0;
    end
  end
endmodule

// File: rtl/daddaStage.sv
module daddaStage
  import daddaPkg::*;
#(
  parameter int STAGE = 0
) (
  input  matrix_t colsIn,
  output matrix_t colsOut
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int H_IN  = plan(STAGE, c, 0);
    localparam int N_FA  = plan(STAGE, c, 1);
    localparam int N_HA  = plan(STAGE, c, 2);
    localparam int N_S   = N_FA + N_HA;
    localparam int USED  = 3 * N_FA + 2 * N_HA;
    localparam int PASS  = H_IN - USED;
    localparam int PREV  = (c > 0) ? c - 1 : 0;
    localparam int P_FA  = (c > 0) ? plan(STAGE, PREV, 1) : 0;
    localparam int P_HA  = (c > 0) ? plan(STAGE, PREV, 2) : 0;
    localparam int OUT_H = PASS + N_S + P_FA + P_HA;

    // untouched bits move down to the lowest rows
    for (genvar p = 0; p < PASS; p++) begin : g_pass
      assign colsOut[c][p] = colsIn[c][USED+p];
    end
    // sums of this column's counters, lowest-weight bits consumed first
    for (genvar k = 0; k < N_FA; k++) begin : g_faSum
      assign colsOut[c][PASS+k] = colsIn[c][3*k] ^ colsIn[c][3*k+1] ^ colsIn[c][3*k+2];
    end
    for (genvar k = 0; k < N_HA; k++) begin : g_haSum
      assign colsOut[c][PASS+N_FA+k] = colsIn[c][3*N_FA+2*k] ^ colsIn[c][3*N_FA+2*k+1];
    end
    // carries arriving from the counters of the column below
    if (c > 0) begin : g_cin
      for (genvar k = 0; k < P_FA; k++) begin : g_faCy
        assign colsOut[c][PASS+N_S+k] =
          (colsIn[PREV][3*k] & colsIn[PREV][3*k+1]) |
          (colsIn[PREV][3*k] & colsIn[PREV][3*k+2]) |
          (colsIn[PREV][3*k+1] & colsIn[PREV][3*k+2]);
      end
      for (genvar k = 0; k < P_HA; k++) begin : g_haCy
        assign colsOut[c][PASS+N_S+P_FA+k] =
          colsIn[PREV][3*P_FA+2*k] & colsIn[PREV][3*P_FA+2*k+1];
      end
    end
    for (genvar p = OUT_H; p < MAXH; p++) begin : g_zero
      assign colsOut[c][p] = 1'b0;
    end
  end

  // R7: the compression must not change the value the matrix represents
  always_comb begin
    int unsigned inSum;
    int unsigned outSum;
    inSum  = 0;
    outSum = 0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < MAXH; r++) begin
        if (colsIn[c][r])  inSum  += (32'd1 << c);
        if (colsOut[c][r]) outSum += (32'd1 << c);
      end
    end
    assert_weight_kept_R7: assert (inSum == outSum)
      else $error("stage %0d weighted sum %0d -> %0d", STAGE, inSum, outSum);
  end
endmodule

// File: rtl/rippleCpa.sv
module rippleCpa #(
  parameter int W = 15
) (
  input  logic [W-1:0] addX,
  input  logic [W-1:0] addY,
  output logic [W:0]   addSum
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign addSum[i]  = addX[i] ^ addY[i] ^ carry[i];
    assign carry[i+1] = (addX[i] & addY[i]) | (carry[i] & (addX[i] ^ addY[i]));
  end
  assign addSum[W] = carry[W];
endmodule

// File: rtl/daddaMul.sv
module daddaMul
  import daddaPkg::*;
(
  input  logic [OPW-1:0]  opA,
  input  logic [OPW-1:0]  opB,
  output logic [COLS-1:0] product
);
  localparam int NSTG = stageCount();

  matrix_t stageMat [NSTG+1];
  logic [COLS-2:0] rowX;
  logic [COLS-2:0] rowY;

  ppMatrix u_pp (
    .mulA  (opA),
    .mulB  (opB),
    .ppCols(stageMat[0])
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    daddaStage #(.STAGE(s)) u_stage (
      .colsIn (stageMat[s]),
      .colsOut(stageMat[s+1])
    );
  end

  for (genvar c = 0; c < COLS - 1; c++) begin : g_rows
    assign rowX[c] = stageMat[NSTG][c][0];
    assign rowY[c] = stageMat[NSTG][c][1];
  end

  rippleCpa #(.W(COLS - 1)) u_cpa (
    .addX  (rowX),
    .addY  (rowY),
    .addSum(product)
  );

  // R8: the reduction leaves at most two rows and nothing in the top column
  always_comb begin
    logic extra;
    extra = |stageMat[NSTG][COLS-1];
    for (int c = 0; c < COLS - 1; c++) extra |= |(stageMat[NSTG][c] >> 2);
    assert_final_two_rows_R8: assert (!extra)
      else $error("final matrix deeper than two rows");
  end

  always_comb begin
    if (opA == '0 || opB == '0) begin
      assert_zero_operand_R3: assert (product == '0)
        else $error("zero operand gave %0h", product);
    end
    if (opB == OPW'(1)) begin
      assert_unit_operand_R4: assert (product == {{OPW{1'b0}}, opA})
        else $error("unit operand gave %0h", product);
    end
    for (int k = 0; k < OPW; k++) begin
      if (opB == (OPW'(1) << k)) begin
        assert_shift_R5: assert (product == ({{OPW{1'b0}}, opA} << k))
          else $error("power-of-two operand gave %0h", product);
      end
    end
    if (product[COLS-1]) begin
      assert_top_bit_R6: assert (opA[OPW-1] && opB[OPW-1])
        else $error("top product bit without both operand msbs");
    end
  end
endmodule

// File: tb/test_daddaMul.sv
module test_daddaMul;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] opA = 8'd0;
  logic [7:0] opB = 8'd0;
  logic [15:0] product;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  daddaMul i_daddaMul (
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h", tag, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    it.a = a;
    it.b = b;
    it.exp = exp;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  function automatic logic [15:0] mulRef(input logic [7:0] a, input logic [7:0] b);
    return {8'd0, a} * {8'd0, b};
  endfunction

  // monitor: results are due in the same cycle, checked at the falling edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      check(it.tag, it.a, it.b, product, it.exp);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R3: state while held in reset with zero operands
    repeat (2) @(negedge clk);
    check("R3 reset state", opA, opB, product, 16'd0);
    rstN = 1'b1;

    // R2: operand change between edges, sampled without a clock edge
    @(negedge clk);
    #1;
    opA = 8'd13;
    opB = 8'd11;
    #1;
    check("R2 no clock", opA, opB, product, 16'd143);
    opB = 8'd200;
    #1;
    check("R2 no clock", opA, opB, product, 16'd2600);

    // R3: zero operands
    apply(8'd0, 8'd255, 16'd0, "R3");
    apply(8'd173, 8'd0, 16'd0, "R3");
    // R4: unit operands
    apply(8'd1, 8'd201, 16'd201, "R4");
    apply(8'd97, 8'd1, 16'd97, "R4");
    // R5: powers of two
    for (int k = 0; k < 8; k++) begin
      apply(8'd183, 8'(1 << k), 16'(16'd183 << k), "R5");
      apply(8'(1 << k), 8'd255, 16'(16'd255 << k), "R5");
    end
    // R6: largest product and top-bit boundary
    apply(8'd255, 8'd255, 16'hFE01, "R6");
    apply(8'd128, 8'd255, 16'd32640, "R6");
    apply(8'd129, 8'd254, 16'd32766, "R6");
    apply(8'd182, 8'd181, 16'd32942, "R6");
    // R9: swapped operands
    apply(8'd37, 8'd222, mulRef(8'd37, 8'd222), "R9");
    apply(8'd222, 8'd37, mulRef(8'd37, 8'd222), "R9");
    apply(8'd170, 8'd85, mulRef(8'd85, 8'd170), "R9");
    apply(8'd85, 8'd170, mulRef(8'd85, 8'd170), "R9");
    // R7 R8: dense carry patterns through every stage and the final adder
    apply(8'd255, 8'd254, 16'd64770, "R7 R8");
    apply(8'd127, 8'd255, 16'd32385, "R7 R8");
    // R1: exhaustive sweep
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        apply(8'(ia), 8'(ib), mulRef(8'(ia), 8'(ib)), "R1");
      end
    end
    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule